// File: doc/BRIEF.md
# Sequenced Status Report Generator

This block lives inside a peripheral and turns a vector of internal status bits into status messages for a host-readable status location. Each message is a 32-bit word: a 26-bit payload and a 6-bit sequence number. The host writes one 8-bit control word. That write chooses one of four reporting modes and loads the starting sequence number. The host can then poll the status location and use the sequence number to tell a fresh report from a stale one.

Messages leave the block on a valid/ready handshake. In the automatic modes a message is sent right after the control write and again each time the status vector differs from the last payload that was accepted. Changes that happen while a message is waiting are folded into the next message. A new control write drops any message that has not been accepted and starts again from the written sequence number. Each generator carries a fixed 8-bit status location number, set by a parameter.

The controller has three states:
- `ST_OFF`: silent.
- `ST_WATCH`: automatic mode with nothing waiting.
- `ST_SEND`: a message is presented.

Its transitions are:
- **write-kick**: any state goes to `ST_SEND` on a control write with a non-zero mode.
- **write-off**: any state goes to `ST_OFF` on a control write with mode 0.
- **change**: `ST_WATCH` goes to `ST_SEND` when the status differs from the last accepted payload.
- **accept-auto**: `ST_SEND` goes to `ST_WATCH` when ready is high in mode 2 or 3.
- **accept-once**: `ST_SEND` goes to `ST_OFF` when ready is high in mode 1.

Top module: `stat_report_gen`

## Requirements
- R1: After synchronous reset the mode is 0, the sequence number is 0, and `msg_valid` is low.
- R2: A control write loads the mode from bits [7:6] and the sequence number from bits [5:0]. With a non-zero mode, `msg_valid` rises in the cycle after the write, carrying the status sampled at the write edge and the written sequence number.
- R3: Mode 0 produces no messages, whatever the status input does.
- R4: Mode 1 sends exactly one message with the programmed sequence number. After that message is accepted, no further message appears until the next control write.
- R5: In mode 2 the sequence number is unchanged after each accepted message.
- R6: In mode 3 the sequence number increases by one after each accepted message and wraps from 63 to 0.
- R7: In modes 2 and 3, with nothing pending, a message is raised one cycle after the status input is sampled unequal to the last accepted payload. No message is raised while the two are equal.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_payload` and `msg_seq` hold steady, unless a control write occurs. A message is accepted when valid and ready are both high at a clock edge.
- R9: Status changes that occur while a message is pending produce one later message that carries the current status value.
- R10: A control write cancels a pending message and starts a new one with the written sequence number. If acceptance and a write fall on the same edge, the written sequence number is used and no increment occurs.
- R11: `msg_addr` always equals the `STAT_ADDR` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_word | input | 8 | Control word: mode [7:6], sequence [5:0] |
| stat_in | input | 26 | Internal status bits to report |
| msg_ready | input | 1 | Consumer ready |
| msg_valid | output | 1 | Message presented |
| msg_payload | output | 26 | Reported status payload |
| msg_seq | output | 6 | Sequence number of the message |
| msg_addr | output | 8 | Status location number of this generator |

## Verification
Two events can land on the same clock edge: a control write and the acceptance of a pending message. In that case the write must win on the sequence number and must start a fresh message, while the accepted message still counts as delivered. The bench makes this happen by holding `msg_ready` high in the cycle of a mode-3 write while an earlier message is still presented. It then checks that the new message carries the written sequence number, not that number plus one, and the sampled payload. A second case puts a write on top of a message that is waiting with ready low, and checks that it is replaced and not delivered twice.

// File: rtl/stat_report_pkg.sv
package stat_report_pkg;
    typedef enum logic [1:0] {
        MODE_OFF       = 2'd0,
        MODE_ONCE      = 2'd1,
        MODE_AUTO_HOLD = 2'd2,
        MODE_AUTO_INC  = 2'd3
    } rpt_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_SEND  = 2'd2
    } rpt_state_e;
endpackage

// File: rtl/stat_mode_ctl.sv
module stat_mode_ctl
    import stat_report_pkg::*;
#(
    parameter int SEQ_W = 6,
    localparam int CW = SEQ_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CW-1:0]    word,
    input  logic             inc,
    output rpt_mode_e        mode,
    output logic [SEQ_W-1:0] seq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_OFF;
            seq  <= '0;
        end else if (we) begin
            mode <= rpt_mode_e'(word[CW-1:SEQ_W]);
            seq  <= word[SEQ_W-1:0];
        end else if (inc) begin
            seq  <= seq + 1'b1;
        end
    end

    // R2: a control write loads the sequence field
    a_r2_seq_load: assert property (@(posedge clk) disable iff (rst)
        we |=> (seq == $past(word[SEQ_W-1:0])));
endmodule

// File: rtl/stat_payload_track.sv
module stat_payload_track #(
    parameter int PAY_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             accept,
    input  logic [PAY_W-1:0] stat_in,
    output logic [PAY_W-1:0] held,
    output logic             differs
);
    logic [PAY_W-1:0] last_sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            last_sent <= '0;
        end else begin
            if (load)   held      <= stat_in;
            if (accept) last_sent <= held;
        end
    end

    assign differs = (stat_in != last_sent);
endmodule

// File: rtl/stat_report_gen.sv
module stat_report_gen
    import stat_report_pkg::*;
#(
    parameter int PAY_W     = 26,
    parameter int SEQ_W     = 6,
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 8'h2A,
    localparam int CW = SEQ_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CW-1:0]     ctl_word,
    input  logic [PAY_W-1:0]  stat_in,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [PAY_W-1:0]  msg_payload,
    output logic [SEQ_W-1:0]  msg_seq,
    output logic [ADDR_W-1:0] msg_addr
);
    rpt_state_e state, nxt;
    rpt_mode_e  mode;
    logic       load, accept, inc, differs;
    rpt_mode_e  wr_mode;

    assign wr_mode = rpt_mode_e'(ctl_word[CW-1:SEQ_W]);
    assign accept  = (state == ST_SEND) && msg_ready;
    assign inc     = accept && (mode == MODE_AUTO_INC) && !ctl_we;

    stat_mode_ctl #(.SEQ_W(SEQ_W)) u_mode (
        .clk(clk), .rst(rst), .we(ctl_we), .word(ctl_word),
        .inc(inc), .mode(mode), .seq(msg_seq)
    );

    stat_payload_track #(.PAY_W(PAY_W)) u_track (
        .clk(clk), .rst(rst), .load(load), .accept(accept),
        .stat_in(stat_in), .held(msg_payload), .differs(differs)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        if (ctl_we) begin
            load = (wr_mode != MODE_OFF);
            nxt  = (wr_mode == MODE_OFF) ? ST_OFF : ST_SEND;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_OFF;
                ST_WATCH: if (differs) begin
                              nxt  = ST_SEND;
                              load = 1'b1;
                          end
                ST_SEND:  if (msg_ready)
                              nxt = (mode == MODE_ONCE) ? ST_OFF : ST_WATCH;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    assign msg_valid = (state == ST_SEND);
    assign msg_addr  = ADDR_W'(STAT_ADDR);

    // R8: presented message holds while stalled
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready && !ctl_we) |=>
            (msg_valid && $stable(msg_payload) && $stable(msg_seq)));
    // R6: increment per accepted message in mode 3
    a_r6_seq_inc: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == MODE_AUTO_INC && !ctl_we) |=>
            (msg_seq == SEQ_W'($past(msg_seq) + 1'b1)));
    // R5: sequence kept in mode 2
    a_r5_seq_hold: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == MODE_AUTO_HOLD && !ctl_we) |=> $stable(msg_seq));
    // R3: mode 0 stays silent
    a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF && !ctl_we) |=> !msg_valid);
    // R4: single request ends after acceptance
    a_r4_single_stop: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == MODE_ONCE && !ctl_we) |=> !msg_valid);
endmodule

// File: tb/stat_report_gen_bench.sv
module stat_report_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_word = '0;
    logic [25:0] stat_in = '0;
    logic        msg_ready = 1'b0;
    logic        msg_valid;
    logic [25:0] msg_payload;
    logic [5:0]  msg_seq;
    logic [7:0]  msg_addr;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stat_report_gen u_stat_report_gen (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_word(ctl_word),
        .stat_in(stat_in), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_payload(msg_payload), .msg_seq(msg_seq), .msg_addr(msg_addr)
    );

    // {tag, we, word, stat, ready, exp_valid, exp_payload, exp_seq}
    localparam int NV = 22;
    localparam logic [72:0] VEC [NV] = '{
        {4'd2,  1'b1, 8'h85, 26'h11, 1'b0, 1'b1, 26'h11, 6'd5},  // R2 kick mode2
        {4'd8,  1'b0, 8'h00, 26'h22, 1'b0, 1'b1, 26'h11, 6'd5},  // R8 stalled hold
        {4'd5,  1'b0, 8'h00, 26'h22, 1'b1, 1'b0, 26'h11, 6'd5},  // R5 seq kept
        {4'd9,  1'b0, 8'h00, 26'h22, 1'b0, 1'b1, 26'h22, 6'd5},  // R9 merged change
        {4'd5,  1'b0, 8'h00, 26'h22, 1'b1, 1'b0, 26'h22, 6'd5},  // R5
        {4'd7,  1'b0, 8'h00, 26'h22, 1'b1, 1'b0, 26'h22, 6'd5},  // R7 no change
        {4'd2,  1'b1, 8'hFE, 26'h33, 1'b0, 1'b1, 26'h33, 6'd62}, // R2 mode3
        {4'd6,  1'b0, 8'h00, 26'h33, 1'b1, 1'b0, 26'h33, 6'd63}, // R6 inc
        {4'd7,  1'b0, 8'h00, 26'h44, 1'b1, 1'b1, 26'h44, 6'd63}, // R7 change
        {4'd6,  1'b0, 8'h00, 26'h44, 1'b1, 1'b0, 26'h44, 6'd0},  // R6 wrap
        {4'd7,  1'b0, 8'h00, 26'h44, 1'b0, 1'b0, 26'h44, 6'd0},  // R7 equal
        {4'd4,  1'b1, 8'h49, 26'h55, 1'b0, 1'b1, 26'h55, 6'd9},  // R4 single
        {4'd4,  1'b0, 8'h00, 26'h66, 1'b1, 1'b0, 26'h55, 6'd9},  // R4 accepted
        {4'd4,  1'b0, 8'h00, 26'h77, 1'b1, 1'b0, 26'h55, 6'd9},  // R4 no second
        {4'd2,  1'b1, 8'h83, 26'h77, 1'b0, 1'b1, 26'h77, 6'd3},  // R2
        {4'd10, 1'b1, 8'hC7, 26'h12, 1'b0, 1'b1, 26'h12, 6'd7},  // R10 cancel
        {4'd3,  1'b1, 8'h00, 26'h12, 1'b0, 1'b0, 26'h12, 6'd0},  // R3 off
        {4'd3,  1'b0, 8'h00, 26'h99, 1'b1, 1'b0, 26'h12, 6'd0},  // R3 silent
        {4'd2,  1'b1, 8'hC4, 26'h05, 1'b0, 1'b1, 26'h05, 6'd4},  // R2
        {4'd10, 1'b1, 8'hCA, 26'h06, 1'b1, 1'b1, 26'h06, 6'd10}, // R10 same edge
        {4'd6,  1'b0, 8'h00, 26'h06, 1'b1, 1'b0, 26'h06, 6'd11}, // R6
        {4'd7,  1'b0, 8'h00, 26'h06, 1'b0, 1'b0, 26'h06, 6'd11}  // R7
    };

    task automatic chk(input int tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] w, input logic [25:0] s, input logic r);
        ctl_we = we; ctl_word = w; stat_in = s; msg_ready = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(1, "valid", 32'(msg_valid), 32'd0);
        chk(1, "seq", 32'(msg_seq), 32'd0);
        step(1'b0, 8'h00, 26'h3A, 1'b1);
        chk(1, "valid after status change", 32'(msg_valid), 32'd0);
        // R11 status location
        chk(11, "addr", 32'(msg_addr), 32'h2A);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][68], VEC[i][67:60], VEC[i][59:34], VEC[i][33]);
            chk(int'(VEC[i][72:69]), "valid",   32'(msg_valid),   32'(VEC[i][32]));
            chk(int'(VEC[i][72:69]), "payload", 32'(msg_payload), 32'(VEC[i][31:6]));
            chk(int'(VEC[i][72:69]), "seq",     32'(msg_seq),     32'(VEC[i][5:0]));
        end

        // R1: reset while a message is pending
        step(1'b1, 8'hD5, 26'h1, 1'b0);
        chk(1, "valid before reset", 32'(msg_valid), 32'd1);
        rst = 1'b1;
        step(1'b0, 8'h00, 26'h1, 1'b0);
        rst = 1'b0;
        chk(1, "valid after reset", 32'(msg_valid), 32'd0);
        chk(1, "seq after reset", 32'(msg_seq), 32'd0);
        step(1'b0, 8'h00, 26'h2, 1'b1);
        step(1'b0, 8'h00, 26'h3, 1'b1);
        chk(3, "silent after reset", 32'(msg_valid), 32'd0);
        chk(11, "addr end", 32'(msg_addr), 32'h2A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule